// File: doc/BRIEF.md
# Dual-Source Interrupt Status Unit

This block keeps the interrupt state for a hash engine and for the DMA channel that feeds it. Each side has its own status register and its own enable register. One-cycle event pulses from the hardware set status bits. Software clears a status bit by writing a one to it. The DMA side also has a one-bit gate register, which must be open before any DMA status can reach the interrupt line. A single registered interrupt output combines both groups.

Software programs the unit through a simple register port. A write strobe, an address and write data update a register on the clock edge. Read data is a combinational decode of the address. A typical sequence is: clear everything, enable the sources of interest, start the operation, and wait for the interrupt. In the interrupt handler, software reads each status register and writes the value it read back to the same register. This clears exactly the bits it has seen. An event that arrives while the handler runs is not lost.

Top module: `dual_irq_status_unit`

## Requirements
- R1: While the reset input is low, every register reads 0 and `irq` is 0.
- R2: An event pulse on an implemented source sets its status bit on the next clock edge. The bit then holds until software clears it, whether or not the matching enable bit is set.
- R3: A write to a status register clears exactly the bits written as 1 and leaves the bits written as 0 untouched. Writing all ones clears the whole group.
- R4: If an event sets a status bit in the same cycle as a write that clears it, the bit stays set.
- R5: Each enable register stores the written value, limited to the implemented bits. A status bit drives the interrupt only while its enable bit is 1, and writing 0 to an enable register silences its whole group.
- R6: The DMA group reaches `irq` only while bit 0 of the gate register (0x488) is 1. The engine group is not affected by the gate.
- R7: `irq` is registered. It rises one clock edge after an enabled status bit becomes set. It falls one clock edge after the last enabled pending bit is cleared.
- R8: Engine status (0x50) and engine enable (0x54) implement bits 3:0, where bit 2 is operation done and bits 0, 1 and 3 are faults. DMA status (0x480) and DMA enable (0x484) implement bit 0 (transfer done) and bits 8:2 (faults). DMA bit 1 and all bits above an implemented field read 0, and events or writes to them have no effect.
- R9: A read from an unmapped address returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_evt | input | 4 | Engine event pulses, one per status bit |
| dma_evt | input | 9 | DMA event pulses, one per status bit |
| irq | output | 1 | Registered interrupt request |

## Verification
Status and enable registers change on the edge that samples an event or a write, so their read-back is valid one edge later. `irq` adds one more register and is valid two edges after the stimulus. Each table entry therefore applies its stimulus for one edge and idles for a second edge, then samples read data and `irq` at the following falling edge. Separate directed tests step one edge at a time and show `irq` still at its old value after the first edge and changed after the second, both when it rises and when it falls.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ENG_W  = 4;
  localparam int unsigned DMA_W  = 9;

  // Implemented bit patterns for each group.
  localparam logic [ENG_W-1:0] ENG_IMPL = 4'hF;
  localparam logic [DMA_W-1:0] DMA_IMPL = 9'h1FD;

  // Register byte addresses.
  localparam logic [ADDR_W-1:0] A_ENG_STAT = 12'h050;
  localparam logic [ADDR_W-1:0] A_ENG_EN   = 12'h054;
  localparam logic [ADDR_W-1:0] A_DMA_STAT = 12'h480;
  localparam logic [ADDR_W-1:0] A_DMA_EN   = 12'h484;
  localparam logic [ADDR_W-1:0] A_DMA_GATE = 12'h488;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENG_STAT,
    SEL_ENG_EN,
    SEL_DMA_STAT,
    SEL_DMA_EN,
    SEL_DMA_GATE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      A_ENG_STAT: decode_addr = SEL_ENG_STAT;
      A_ENG_EN:   decode_addr = SEL_ENG_EN;
      A_DMA_STAT: decode_addr = SEL_DMA_STAT;
      A_DMA_EN:   decode_addr = SEL_DMA_EN;
      A_DMA_GATE: decode_addr = SEL_DMA_GATE;
      default:    decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/isu_status_group.sv
module isu_status_group #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         pending
);
  logic [W-1:0] st_q, st_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] evt_m;
  logic         st_ce;

  assign evt_m = evt & IMPL;
  assign st_ce = clr_we | (|evt_m);

  // Next state: the write-1 clear is applied first, then events are
  // merged on top, so a same-cycle event wins.
  always_comb begin
    st_d = st_q;
    if (clr_we) st_d = st_d & ~wdata;
    st_d = (st_d | evt_m) & IMPL;
    en_d = wdata & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      if (st_ce) st_q <= st_d;
      if (en_we) en_q <= en_d;
    end
  end

  assign status  = st_q;
  assign enable  = en_q;
  assign pending = |(st_q & en_q);

  // R4: an event always leaves its bit set, whatever the write does.
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_m != '0) |=> ((st_q & $past(evt_m)) == $past(evt_m)));

  // R3: cleared bits with no competing event read 0 afterwards.
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_m == '0) |=> ((st_q & $past(wdata)) == '0));

  // R2: without event or clear the status holds.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && evt_m == '0) |=> $stable(st_q));

  // R5: the enable register changes only on its own write.
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));

  // R8: unimplemented bits never become set.
  p_impl_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q) & ~IMPL) == '0);
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
  import isu_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned D_W = DATA_W,
  parameter int unsigned EW  = ENG_W,
  parameter int unsigned DW  = DMA_W
) (
  input  logic [A_W-1:0] addr,
  input  logic [EW-1:0]  eng_st,
  input  logic [EW-1:0]  eng_en,
  input  logic [DW-1:0]  dma_st,
  input  logic [DW-1:0]  dma_en,
  input  logic           dma_gate,
  output logic [D_W-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    sel = decode_addr(addr);
    case (sel)
      SEL_ENG_STAT: rdata = D_W'(eng_st);
      SEL_ENG_EN:   rdata = D_W'(eng_en);
      SEL_DMA_STAT: rdata = D_W'(dma_st);
      SEL_DMA_EN:   rdata = D_W'(dma_en);
      SEL_DMA_GATE: rdata = D_W'(dma_gate);
      default:      rdata = '0;
    endcase
  end

  // R9: an unmapped address reads as zero.
  always_comb begin
    if (sel == SEL_NONE) begin
      p_unmapped_zero_r9: assert (rdata == '0);
    end
  end
endmodule

// File: rtl/dual_irq_status_unit.sv
module dual_irq_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned D_W = DATA_W,
  parameter int unsigned EW  = ENG_W,
  parameter int unsigned DW  = DMA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] bus_addr,
  input  logic           bus_wr_en,
  input  logic [D_W-1:0] bus_wdata,
  output logic [D_W-1:0] bus_rdata,
  input  logic [EW-1:0]  eng_evt,
  input  logic [DW-1:0]  dma_evt,
  output logic           irq
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Write decode.
  reg_sel_e wsel;
  logic     eng_clr_we, eng_en_we, dma_clr_we, dma_en_we, gate_we;

  always_comb begin
    wsel       = decode_addr(bus_addr);
    eng_clr_we = bus_wr_en && (wsel == SEL_ENG_STAT);
    eng_en_we  = bus_wr_en && (wsel == SEL_ENG_EN);
    dma_clr_we = bus_wr_en && (wsel == SEL_DMA_STAT);
    dma_en_we  = bus_wr_en && (wsel == SEL_DMA_EN);
    gate_we    = bus_wr_en && (wsel == SEL_DMA_GATE);
  end

  logic [EW-1:0] eng_st, eng_en;
  logic [DW-1:0] dma_st, dma_en;
  logic          eng_pend, dma_pend;

  isu_status_group #(.W(EW), .IMPL(ENG_IMPL)) u_eng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (eng_evt),
    .clr_we  (eng_clr_we),
    .en_we   (eng_en_we),
    .wdata   (bus_wdata[EW-1:0]),
    .status  (eng_st),
    .enable  (eng_en),
    .pending (eng_pend)
  );

  isu_status_group #(.W(DW), .IMPL(DMA_IMPL)) u_dma (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (dma_evt),
    .clr_we  (dma_clr_we),
    .en_we   (dma_en_we),
    .wdata   (bus_wdata[DW-1:0]),
    .status  (dma_st),
    .enable  (dma_en),
    .pending (dma_pend)
  );

  // DMA gate register.
  logic gate_q, gate_d;
  assign gate_d = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   gate_q <= 1'b0;
    else if (gate_we) gate_q <= gate_d;
  end

  // Interrupt output register.
  logic irq_q, irq_d;
  assign irq_d = eng_pend | (dma_pend & gate_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq = irq_q;

  isu_read_mux #(.A_W(A_W), .D_W(D_W), .EW(EW), .DW(DW)) u_rd (
    .addr     (bus_addr),
    .eng_st   (eng_st),
    .eng_en   (eng_en),
    .dma_st   (dma_st),
    .dma_en   (dma_en),
    .dma_gate (gate_q),
    .rdata    (bus_rdata)
  );

  // R7: an enabled engine source raises irq on the next edge.
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_pend |=> irq);

  // R7: with nothing pending in either group, irq drops on the next edge.
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!eng_pend && !dma_pend) |=> !irq);

  // R6: a closed gate blocks the DMA group.
  p_gate_block_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!gate_q && !eng_pend) |=> !irq);

  // R6: an open gate passes a pending DMA source.
  p_gate_pass_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gate_q && dma_pend) |=> irq);

  // R1: while reset is held, the output stays low.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !irq);
endmodule

// File: tb/tb_dual_irq_status_unit.sv
module tb_dual_irq_status_unit;
  localparam logic [11:0] ES = 12'h050;
  localparam logic [11:0] EE = 12'h054;
  localparam logic [11:0] DS = 12'h480;
  localparam logic [11:0] DE = 12'h484;
  localparam logic [11:0] DM = 12'h488;
  localparam logic [11:0] UN = 12'h100;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  eng_evt;
  logic [8:0]  dma_evt;
  logic        irq;

  int n_checks;
  int n_fail;

  dual_irq_status_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_evt   (eng_evt),
    .dma_evt   (dma_evt),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [3:0]  eev;
    logic [8:0]  dev;
    logic [11:0] raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,        4'h4, 9'h000, ES, 32'h4,   1'b0, 8'd2}, // R2 latch, enable off
    '{1'b1, EE,      32'h4,        4'h0, 9'h000, EE, 32'h4,   1'b1, 8'd5}, // R5 enable -> irq
    '{1'b1, ES,      32'h4,        4'h0, 9'h000, ES, 32'h0,   1'b0, 8'd3}, // R3 clear
    '{1'b0, 12'h000, 32'h0,        4'h0, 9'h003, DS, 32'h1,   1'b0, 8'd8}, // R8 DMA bit 1 absent
    '{1'b1, DE,      32'h1FD,      4'h0, 9'h000, DE, 32'h1FD, 1'b0, 8'd6}, // R6 gate closed
    '{1'b1, DM,      32'h1,        4'h0, 9'h000, DM, 32'h1,   1'b1, 8'd6}, // R6 gate open
    '{1'b1, DM,      32'h0,        4'h0, 9'h000, DM, 32'h0,   1'b0, 8'd6}, // R6 gate closed again
    '{1'b1, DE,      32'hFFFFFFFF, 4'h0, 9'h000, DE, 32'h1FD, 1'b0, 8'd8}, // R8 enable limited
    '{1'b0, 12'h000, 32'h0,        4'h0, 9'h100, DS, 32'h101, 1'b0, 8'd2}, // R2 accumulate
    '{1'b1, DS,      32'h1,        4'h0, 9'h000, DS, 32'h100, 1'b0, 8'd3}, // R3 partial clear
    '{1'b0, 12'h000, 32'h0,        4'hB, 9'h000, ES, 32'hB,   1'b0, 8'd5}, // R5 faults latch, disabled
    '{1'b1, EE,      32'h0,        4'h0, 9'h000, ES, 32'hB,   1'b0, 8'd5}, // R5 zero enable
    '{1'b1, EE,      32'h8,        4'h0, 9'h000, EE, 32'h8,   1'b1, 8'd5}, // R5 one fault enabled
    '{1'b1, ES,      32'hFFFFFFFF, 4'h0, 9'h000, ES, 32'h0,   1'b0, 8'd3}, // R3 clear all
    '{1'b1, UN,      32'hFFFF,     4'h0, 9'h000, UN, 32'h0,   1'b0, 8'd9}, // R9 unmapped
    '{1'b1, DS,      32'hFFFFFFFF, 4'h0, 9'h000, DS, 32'h0,   1'b0, 8'd3}, // R3 clear all DMA
    '{1'b1, DM,      32'h1,        4'h0, 9'h000, ES, 32'h0,   1'b0, 8'd6}  // R6 open gate, nothing pending
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr_en = 1'b0;
    bus_addr  = 12'h000;
    bus_wdata = '0;
    eng_evt   = '0;
    dma_evt   = '0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a,
                          input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, "read", bus_rdata, exp);
  endtask

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "irq in reset", {31'b0, irq}, 32'h0);
    read_chk("R1", ES, 32'h0);
    read_chk("R1", DE, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: stimulus for one edge, idle edge, then sample.
    for (int i = 0; i < NV; i++) begin
      bus_wr_en = VEC[i].wr;
      bus_addr  = VEC[i].waddr;
      bus_wdata = VEC[i].wdata;
      eng_evt   = VEC[i].eev;
      dma_evt   = VEC[i].dev;
      @(negedge clk);
      idle();
      @(negedge clk);
      read_chk($sformatf("R%0d", VEC[i].req), VEC[i].raddr, VEC[i].exp_rd);
      check($sformatf("R%0d", VEC[i].req), "irq", {31'b0, irq}, {31'b0, VEC[i].exp_irq});
    end

    // R4: event and clear of the same bit in one cycle.
    bus_wr_en = 1'b1; bus_addr = ES; bus_wdata = 32'hF; eng_evt = 4'h2;
    @(negedge clk);
    idle();
    @(negedge clk);
    read_chk("R4", ES, 32'h2);
    check("R4", "irq", {31'b0, irq}, 32'h0);

    // R7: rise is one edge after the status bit sets.
    eng_evt = 4'h8;
    @(negedge clk);
    idle();
    read_chk("R7", ES, 32'hA);
    check("R7", "irq before", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7", "irq rise", {31'b0, irq}, 32'h1);
    // R7: fall is one edge after the clear.
    bus_wr_en = 1'b1; bus_addr = ES; bus_wdata = 32'h8;
    @(negedge clk);
    idle();
    read_chk("R7", ES, 32'h2);
    check("R7", "irq still", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7", "irq fall", {31'b0, irq}, 32'h0);

    // R6: DMA done through an open gate.
    dma_evt = 9'h001;
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R6", "dma irq", {31'b0, irq}, 32'h1);

    // R1: asynchronous reset mid-run.
    rst_n = 1'b0;
    #1;
    check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    read_chk("R1", ES, 32'h0);
    read_chk("R1", DS, 32'h0);
    read_chk("R1", EE, 32'h0);
    read_chk("R1", DM, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule